// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the five interrupt flags of a 16-bit timer/counter that has three output compare channels (A, B, C), one input capture channel and an overflow event. Each cycle it compares the counter value from the timer core with the three compare values and the capture register. It also watches a capture strobe that is already synchronized and the waveform mode. From these it sets flags that stay set until software or the interrupt controller clears them.

Software reads the flags through an 8-bit register image. To clear flags, software writes ones to the flag positions. When the interrupt controller runs a flag's vector, it sends a one-cycle acknowledge pulse on that flag's line, which also clears the flag. Each flag drives its own interrupt request, gated by a per-flag enable. The counter, waveform generation, pin control and interrupt arbitration belong to other blocks.

Top module: `tifr_flag_reg`

## Requirements
- R1: Register image bit positions: bit 0 = overflow, bit 1 = compare A, bit 2 = compare B, bit 3 = compare C, bit 5 = capture. The internal flag order used by `ack_i`, `irq_en_i` and `irq_o` is index 0 overflow, 1 A, 2 B, 3 C, 4 capture.
- R2: Bits 4, 6 and 7 of `flags_o` always read zero. Writes to those bits change no flag.
- R3: A compare flag rises at the clock edge that ends a cycle in which `cnt_i` equals that channel's compare value. It is not yet set during the match cycle itself.
- R4: The force strobes `force_i` never set any compare flag.
- R5: In modes 8, 10, 12 and 14 the capture register serves as TOP. In those modes the capture flag rises at the edge after `cnt_i == icr_i`, and `cap_stb_i` is ignored. In all other modes the capture flag rises at the edge after `cap_stb_i` is high.
- R6: In modes 0, 4 and 12 the overflow flag rises at the edge after `cnt_i == 16'hFFFF`. In every other mode it is never set.
- R7: An `ack_i` pulse clears its flag at the next edge.
- R8: A write with `wr_en_i` high clears each flag whose bit in `wr_data_i` is one. Flags whose bit is zero keep their value.
- R9: If a set event and a clear (write-one or acknowledge) reach a flag in the same cycle, the flag ends up at one.
- R10: Reset clears every flag. Set events present at the first clock edge after reset release are dropped.
- R11: `irq_o[i]` is high exactly when flag i is set and `irq_en_i[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Current counter value |
| ocr_a_i | input | 16 | Compare value, channel A |
| ocr_b_i | input | 16 | Compare value, channel B |
| ocr_c_i | input | 16 | Compare value, channel C |
| icr_i | input | 16 | Capture register value |
| mode_i | input | 4 | Waveform mode |
| cap_stb_i | input | 1 | Synchronized capture edge strobe |
| force_i | input | 3 | Force-compare strobes, C/B/A |
| ack_i | input | 5 | Per-flag vector acknowledge pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| irq_en_i | input | 5 | Per-flag interrupt enables |
| flags_o | output | 8 | Readable flag register image |
| irq_o | output | 5 | Per-flag interrupt requests |

## Verification
Properties check the following on every cycle: reserved bits stay at zero; set beats clear; a clear with no set empties the flag; a channel A match is followed by the flag; force strobes without a match leave the flag unchanged; overflow stays quiet outside its modes; the first edge after reset leaves all flags at zero; each request implies both its enable and its flag. Only directed scenarios can show the exact one-cycle delay relative to the match cycle, the swap of the capture source when the mode changes, the bit positions seen in the register image, and the pairing of each acknowledge line with its flag.

// File: rtl/tifr_pkg.sv
package tifr_pkg;
  localparam int NFLAG = 5;
  localparam int F_OVF = 0;
  localparam int F_CA  = 1;
  localparam int F_CB  = 2;
  localparam int F_CC  = 3;
  localparam int F_CAP = 4;

  typedef logic [3:0] mode_t;

  // register image position of each internal flag
  function automatic int flag_pos(input int idx);
    return (idx == F_CAP) ? 5 : idx;
  endfunction

  function automatic logic icr_is_top(input mode_t m);
    return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
  endfunction

  function automatic logic ovf_active(input mode_t m);
    return (m == 4'd0) || (m == 4'd4) || (m == 4'd12);
  endfunction
endpackage

// File: rtl/tifr_event_gen.sv
module tifr_event_gen
  import tifr_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NCMP = 3
) (
  input  logic [CW-1:0]           cnt_i,
  input  logic [NCMP-1:0][CW-1:0] cmp_i,
  input  logic [CW-1:0]           icr_i,
  input  mode_t                   mode_i,
  input  logic                    cap_stb_i,
  output logic [NCMP+1:0]         set_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_comb set_o[0] = ovf_active(mode_i) && (cnt_i == CNT_MAX);

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    always_comb set_o[c+1] = (cnt_i == cmp_i[c]);
  end

  always_comb set_o[NCMP+1] = icr_is_top(mode_i) ? (cnt_i == icr_i) : cap_stb_i;
endmodule

// File: rtl/tifr_flag_bit.sv
module tifr_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !q_o) |=> !q_o);
endmodule

// File: rtl/tifr_flag_reg.sv
module tifr_flag_reg
  import tifr_pkg::*;
#(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    cnt_i,
  input  logic [CW-1:0]    ocr_a_i,
  input  logic [CW-1:0]    ocr_b_i,
  input  logic [CW-1:0]    ocr_c_i,
  input  logic [CW-1:0]    icr_i,
  input  logic [3:0]       mode_i,
  input  logic             cap_stb_i,
  input  logic [2:0]       force_i,
  input  logic [NFLAG-1:0] ack_i,
  input  logic             wr_en_i,
  input  logic [RW-1:0]    wr_data_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic [RW-1:0]    flags_o,
  output logic [NFLAG-1:0] irq_o
);
  localparam int NCMP = 3;

  logic [NFLAG-1:0] set_raw, set_eff, clr, q;
  logic             arm_q;

  // drops set events on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= 1'b1;
  end

  tifr_event_gen #(.CW(CW), .NCMP(NCMP)) u_evt (
    .cnt_i     (cnt_i),
    .cmp_i     ({ocr_c_i, ocr_b_i, ocr_a_i}),
    .icr_i     (icr_i),
    .mode_i    (mode_i),
    .cap_stb_i (cap_stb_i),
    .set_o     (set_raw)
  );

  assign set_eff = set_raw & {NFLAG{arm_q}};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign clr[i] = ack_i[i] | (wr_en_i & wr_data_i[flag_pos(i)]);
    tifr_flag_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_eff[i]),
      .clr_i  (clr[i]),
      .q_o    (q[i])
    );
  end

  always_comb begin
    flags_o = '0;
    for (int i = 0; i < NFLAG; i++) flags_o[flag_pos(i)] = q[i];
  end

  assign irq_o = q & irq_en_i;

  assert_rsv_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[7:6] == 2'b00) && !flags_o[4]);
  assert_cmp_a_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && (cnt_i == ocr_a_i)) |=> flags_o[1]);
  assert_force_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i[0] && (cnt_i != ocr_a_i) && !flags_o[1]) |=> !flags_o[1]);
  assert_ovf_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_active(mode_i) && !flags_o[0]) |=> !flags_o[0]);
  assert_first_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_q |=> (flags_o == '0));
  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~(irq_en_i & q)) == '0));
endmodule

// File: tb/tifr_flag_reg_tb.sv
module tifr_flag_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDLE = 16'h0100;
  localparam logic [15:0] CA = 16'h1000, CB = 16'h2000, CC = 16'h3000, ICR = 16'h4000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] cnt_i, ocr_a_i, ocr_b_i, ocr_c_i, icr_i;
  logic [3:0]  mode_i;
  logic        cap_stb_i, wr_en_i;
  logic [2:0]  force_i;
  logic [4:0]  ack_i, irq_en_i, irq_o;
  logic [7:0]  wr_data_i, flags_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tifr_flag_reg dut_i (
    .clk_i, .rst_ni, .cnt_i, .ocr_a_i, .ocr_b_i, .ocr_c_i, .icr_i, .mode_i,
    .cap_stb_i, .force_i, .ack_i, .wr_en_i, .wr_data_i, .irq_en_i,
    .flags_o, .irq_o
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    wr_en_i = 1'b1; wr_data_i = 8'hFF;
    tick();
    wr_en_i = 1'b0; wr_data_i = 8'h00;
  endtask

  task automatic t_reset();
    cnt_i = CA;
    #1;
    chk("R10 reset state", flags_o, 8'h00);
    rst_ni = 1'b1;
    tick();
    chk("R10 first edge drops set", flags_o, 8'h00);
    tick();
    chk("R10 set after first edge", flags_o, 8'h02);
    cnt_i = IDLE;
    clear_all();
  endtask

  task automatic t_compare();
    logic [15:0] vals [3];
    vals[0] = CA; vals[1] = CB; vals[2] = CC;
    for (int c = 0; c < 3; c++) begin
      cnt_i = vals[c];
      #1;
      chk("R3 not set in match cycle", flags_o, 8'h00);
      tick();
      cnt_i = IDLE;
      chk("R3/R1 compare flag position", flags_o, 8'(1 << (c + 1)));
      wr_en_i = 1'b1; wr_data_i = 8'(1 << (c + 1));
      tick();
      wr_en_i = 1'b0; wr_data_i = 8'h00;
      chk("R8 write one clears", flags_o, 8'h00);
    end
  endtask

  task automatic t_force();
    force_i = 3'b111;
    tick(); tick(); tick();
    force_i = 3'b000;
    chk("R4 force sets nothing", flags_o, 8'h00);
  endtask

  task automatic t_capture();
    mode_i = 4'd0;
    cap_stb_i = 1'b1;
    tick();
    cap_stb_i = 1'b0;
    chk("R5/R1 capture strobe", flags_o, 8'h20);
    ack_i = 5'b10000;
    tick();
    ack_i = '0;
    chk("R7 ack clears capture", flags_o, 8'h00);
    mode_i = 4'd14;
    cap_stb_i = 1'b1;
    tick();
    cap_stb_i = 1'b0;
    chk("R5 strobe ignored in TOP mode", flags_o, 8'h00);
    cnt_i = ICR;
    tick();
    cnt_i = IDLE;
    chk("R5 TOP reached sets capture", flags_o, 8'h20);
    mode_i = 4'd0;
    clear_all();
  endtask

  task automatic t_overflow();
    mode_i = 4'd0;
    cnt_i = 16'hFFFF;
    tick();
    cnt_i = IDLE;
    chk("R6 overflow normal mode", flags_o, 8'h01);
    ack_i = 5'b00001;
    tick();
    ack_i = '0;
    chk("R7 ack clears overflow", flags_o, 8'h00);
    mode_i = 4'd1;
    cnt_i = 16'hFFFF;
    tick();
    cnt_i = IDLE;
    chk("R6 no overflow in mode 1", flags_o, 8'h00);
    mode_i = 4'd4;
    cnt_i = 16'hFFFF;
    tick();
    cnt_i = IDLE;
    chk("R6 overflow mode 4", flags_o, 8'h01);
    mode_i = 4'd0;
    clear_all();
  endtask

  task automatic t_write();
    cnt_i = CA;
    tick();
    cnt_i = IDLE;
    wr_en_i = 1'b1; wr_data_i = 8'h00;
    tick();
    chk("R8 write zero keeps flag", flags_o, 8'h02);
    wr_data_i = 8'hD0;
    tick();
    wr_en_i = 1'b0; wr_data_i = 8'h00;
    chk("R2 reserved write no effect", flags_o, 8'h02);
    ack_i = 5'b11101;
    tick();
    ack_i = '0;
    chk("R7 other acks keep flag A", flags_o, 8'h02);
    clear_all();
    chk("R2 reserved read zero", flags_o & 8'hD0, 8'h00);
  endtask

  task automatic t_set_wins();
    cnt_i = CB;
    wr_en_i = 1'b1; wr_data_i = 8'h04;
    tick();
    wr_en_i = 1'b0; wr_data_i = 8'h00;
    chk("R9 set beats write clear", flags_o, 8'h04);
    cnt_i = CB;
    ack_i = 5'b00100;
    tick();
    ack_i = '0;
    cnt_i = IDLE;
    chk("R9 set beats ack", flags_o, 8'h04);
    clear_all();
  endtask

  task automatic t_irq();
    cnt_i = CA;
    tick();
    cnt_i = IDLE;
    irq_en_i = '0;
    #1;
    chk("R11 disabled no request", 8'(irq_o), 8'h00);
    irq_en_i = 5'b00010;
    #1;
    chk("R11 enabled request", 8'(irq_o), 8'h02);
    irq_en_i = 5'b11101;
    #1;
    chk("R11 other enables", 8'(irq_o), 8'h00);
    irq_en_i = '0;
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    cnt_i = IDLE; ocr_a_i = CA; ocr_b_i = CB; ocr_c_i = CC; icr_i = ICR;
    mode_i = 4'd0; cap_stb_i = 1'b0; force_i = '0; ack_i = '0;
    wr_en_i = 1'b0; wr_data_i = '0; irq_en_i = '0;
    tick(); tick();
    t_reset();
    t_compare();
    t_force();
    t_capture();
    t_overflow();
    t_write();
    t_set_wins();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule